// File: doc/BRIEF.md
# Pulse-Height Channel Front-End Sequencer

This block sequences one input channel of a four-channel pulse-height converter. A comparator outside the block reports when the analog pulse crosses its threshold. The block then latches a busy state, enables the peak-hold path and opens a view window whose length is programmable. When the external peak detector reports that the peak has been found, the block issues a single fixed-width convert pulse. A fixed number of cycles later it raises a conversion-done flag.

When the view window closes, the block samples the external gate. If the gate is still high at that moment, the channel is flagged as part of the coincidence event. If the gate is low, the channel still converts, but the coincidence flag stays low so that readout skips it. The block has no timeout of its own. The channel stays busy until a clear arrives. That clear is shared by all channels, so they all release in the same cycle. After the clear, the channel re-arms only on a fresh rising edge of the threshold input.

All timing is in cycles of a 100 MHz clock. The convert pulse lasts 6 cycles, which is 60 ns. Each view step lasts 50 cycles, which is 0.5 us. The 5-bit view setting therefore spans 0 to 15.5 us.

Top module: `pha_channel_ctrl`

## Requirements
- R1: While `chan_en` is low, `busy` and `hold_en` are low from the next cycle on. `busy` never rises unless `chan_en` was high in the cycle before.
- R2: A low-to-high change of `thr_in` while enabled, idle and not cleared sets `busy` at the next clock edge. `hold_en` is high exactly while `busy` is high.
- R3: Threshold edges while busy are ignored and do not restart the view window. After a clear, a `thr_in` level that is still high does not re-arm the channel; only a new rising edge does.
- R4: `view_win` rises in the same cycle as `busy`. It stays high for `view_sel` × 50 cycles, using the value of `view_sel` sampled when the channel arms. A `view_sel` of 0 opens no window.
- R5: The first `peak_stb` cycle while busy starts a convert pulse on the next cycle, 6 cycles wide. Only one pulse is issued per event. A strobe while not busy has no effect.
- R6: `conv_done` rises 26 cycles after the rising edge of the convert pulse, which is 20 cycles after its end. It stays high until the channel is cleared.
- R7: `coinc_valid` is set from the cycle after the window closes if `gate_in` was high in the last window cycle. For a `view_sel` of 0, the gate is sampled in the arming cycle instead. Otherwise `coinc_valid` stays low. A gate that rises after the window has closed has no effect, and conversion proceeds either way.
- R8: Only `fe_clr` (or dropping `chan_en`) ends busy; busy lasts indefinitely without it. One cycle of clear drops `busy`, `view_win`, `coinc_valid`, `conv_pulse` and `conv_done` on the next cycle. Clear overrides a threshold edge in the same cycle.
- R9: During and directly after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable |
| thr_in | input | 1 | Threshold comparator output |
| peak_stb | input | 1 | Peak-found strobe |
| view_sel | input | SEL_W | View length in steps of STEP_CYC cycles |
| gate_in | input | 1 | External coincidence gate |
| fe_clr | input | 1 | Shared front-end clear |
| busy | output | 1 | Channel busy |
| hold_en | output | 1 | Peak-hold enable |
| conv_pulse | output | 1 | Convert pulse, CONV_CYC cycles wide |
| view_win | output | 1 | View window |
| coinc_valid | output | 1 | Channel belongs to the coincidence event |
| conv_done | output | 1 | Conversion finished |

## Verification
The assertions check the causal rules on every cycle:
- busy rises only from an enabled threshold input, and never without a clear after it has started;
- the window and the convert pulse appear only inside busy;
- a coincidence flag is always preceded by a high gate;
- a clear empties every output.

Only the bench scenarios can show the exact cycle counts and the edge cases around the counts:
- the window length for several settings, including 0 and 31;
- the 6-cycle pulse and the 26-cycle done latency;
- a gate that arrives only in the final window cycle or just after the window;
- re-arming after a clear while the threshold input stays high.

// File: rtl/pha_channel_ctrl.sv
module pha_channel_ctrl #(
  parameter int STEP_CYC = 50,
  parameter int SEL_W    = 5,
  parameter int CONV_CYC = 6,
  parameter int DONE_LAT = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             thr_in,
  input  logic             peak_stb,
  input  logic [SEL_W-1:0] view_sel,
  input  logic             gate_in,
  input  logic             fe_clr,
  output logic             busy,
  output logic             hold_en,
  output logic             conv_pulse,
  output logic             view_win,
  output logic             coinc_valid,
  output logic             conv_done
);
  localparam int VIEW_MAX = STEP_CYC * ((1 << SEL_W) - 1);
  localparam int VW       = $clog2(VIEW_MAX + 1);
  localparam int CONV_TOT = CONV_CYC + DONE_LAT;
  localparam int CW       = $clog2(CONV_TOT + 1);

  logic          thr_q, busy_q, view_q, coinc_q, conv_used, done_q;
  logic [VW-1:0] view_cnt;
  logic [CW-1:0] conv_cnt;
  logic [VW-1:0] view_len;
  logic          kill, arm, fire, view_last;

  assign kill      = fe_clr || !chan_en;
  assign arm       = !kill && !busy_q && thr_in && !thr_q;
  assign fire      = busy_q && !kill && peak_stb && !conv_used;
  assign view_len  = VW'(view_sel) * VW'(STEP_CYC);
  assign view_last = view_q && (view_cnt == VW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) thr_q <= 1'b1;
    else        thr_q <= thr_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || kill) busy_q <= 1'b0;
    else if (arm)       busy_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      view_q   <= 1'b0;
      view_cnt <= '0;
    end else if (arm) begin
      view_q   <= (view_len != '0);
      view_cnt <= view_len;
    end else if (view_q) begin
      view_cnt <= view_cnt - VW'(1);
      if (view_last) view_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || kill)                coinc_q <= 1'b0;
    else if (arm && view_len == '0)    coinc_q <= gate_in;
    else if (view_last)                coinc_q <= gate_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      conv_cnt  <= '0;
      conv_used <= 1'b0;
      done_q    <= 1'b0;
    end else if (fire) begin
      conv_cnt  <= CW'(CONV_TOT);
      conv_used <= 1'b1;
    end else if (conv_cnt != '0) begin
      conv_cnt <= conv_cnt - CW'(1);
      if (conv_cnt == CW'(1)) done_q <= 1'b1;
    end
  end

  assign busy        = busy_q;
  assign hold_en     = busy_q;
  assign view_win    = view_q;
  assign coinc_valid = coinc_q;
  assign conv_done   = done_q;
  assign conv_pulse  = conv_cnt > CW'(DONE_LAT);
endmodule

// File: rtl/pha_channel_chk.sv
module pha_channel_chk (
  input logic clk,
  input logic rst_n,
  input logic chan_en,
  input logic thr_in,
  input logic peak_stb,
  input logic gate_in,
  input logic fe_clr,
  input logic busy,
  input logic conv_pulse,
  input logic view_win,
  input logic coinc_valid,
  input logic conv_done
);
  assert_dis_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !busy);
  assert_rise_needs_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(chan_en));
  assert_arm_from_thr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(thr_in) && !$past(fe_clr)));
  assert_view_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    view_win |-> busy);
  assert_view_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(view_win) |-> $rose(busy));
  assert_conv_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_pulse) |-> ($past(peak_stb) && $past(busy)));
  assert_conv_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_pulse |-> busy);
  assert_done_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_done) |-> (!conv_pulse && busy));
  assert_coinc_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coinc_valid) |-> $past(gate_in));
  assert_no_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chan_en && !fe_clr) |=> busy);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fe_clr |=> (!busy && !view_win && !coinc_valid && !conv_done && !conv_pulse));
endmodule

bind pha_channel_ctrl pha_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .thr_in(thr_in),
  .peak_stb(peak_stb), .gate_in(gate_in), .fe_clr(fe_clr), .busy(busy),
  .conv_pulse(conv_pulse), .view_win(view_win), .coinc_valid(coinc_valid),
  .conv_done(conv_done)
);

// File: tb/test_pha_channel_ctrl.sv
module test_pha_channel_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic chan_en = 1'b0, thr_in = 1'b0, peak_stb = 1'b0, gate_in = 1'b0, fe_clr = 1'b0;
  logic [4:0] view_sel = '0;
  logic busy, hold_en, conv_pulse, view_win, coinc_valid, conv_done;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  pha_channel_ctrl i_pha_channel_ctrl (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .thr_in(thr_in),
    .peak_stb(peak_stb), .view_sel(view_sel), .gate_in(gate_in), .fe_clr(fe_clr),
    .busy(busy), .hold_en(hold_en), .conv_pulse(conv_pulse), .view_win(view_win),
    .coinc_valid(coinc_valid), .conv_done(conv_done)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_chan();
    fe_clr = 1'b1; thr_in = 1'b0; gate_in = 1'b0; peak_stb = 1'b0;
    tick();
    fe_clr = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; thr_in = 1'b1;
    tick(3);
    chk("R9 busy in reset", busy, 0);
    chk("R9 outputs in reset", {hold_en, conv_pulse, view_win, coinc_valid, conv_done}, 0);
    rst_n = 1'b1; chan_en = 1'b1;
    tick(2);
    chk("R9 busy after reset with held threshold", busy, 0);
    thr_in = 1'b0;
    tick();
  endtask

  task automatic t_event();
    int n;
    view_sel = 5'd2; gate_in = 1'b1; thr_in = 1'b1;
    tick();
    chk("R2 busy set", busy, 1);
    chk("R2 hold follows busy", hold_en, 1);
    chk("R4 window opens with busy", view_win, 1);
    n = 0;
    while (view_win && n < 5000) begin n++; tick(); end
    chk("R4 window length sel=2", n, 100);
    chk("R7 coinc with gate held", coinc_valid, 1);
    peak_stb = 1'b1; tick(); peak_stb = 1'b0;
    chk("R5 convert starts", conv_pulse, 1);
    n = 0;
    while (conv_pulse && n < 100) begin n++; tick(); end
    chk("R5 convert width", n, 6);
    while (!conv_done && n < 200) begin n++; tick(); end
    chk("R6 done latency from pulse rise", n, 26);
    peak_stb = 1'b1; tick(); peak_stb = 1'b0; tick();
    chk("R5 second strobe ignored", conv_pulse, 0);
    tick(500);
    chk("R8 busy without timeout", busy, 1);
    chk("R6 done held", conv_done, 1);
    fe_clr = 1'b1; tick(); fe_clr = 1'b0;
    chk("R8 clear drops all", {busy, hold_en, coinc_valid, conv_done, view_win}, 0);
    thr_in = 1'b0; gate_in = 1'b0;
    tick();
  endtask

  task automatic t_gate_miss();
    int n;
    view_sel = 5'd1; gate_in = 1'b1; thr_in = 1'b1;
    tick();
    n = 0;
    while (view_win && n < 5000) begin
      n++;
      if (n == 45) gate_in = 1'b0;
      tick();
    end
    chk("R4 window length sel=1", n, 50);
    gate_in = 1'b1; tick();
    chk("R7 gate dropped early and late gate ignored", coinc_valid, 0);
    peak_stb = 1'b1; tick(); peak_stb = 1'b0;
    chk("R7 converts without coincidence", conv_pulse, 1);
    clear_chan();
  endtask

  task automatic t_gate_last();
    int n;
    view_sel = 5'd3; gate_in = 1'b0; thr_in = 1'b1;
    tick();
    n = 0;
    while (view_win && n < 5000) begin
      n++;
      if (n == 150) gate_in = 1'b1;
      tick();
    end
    chk("R4 window length sel=3", n, 150);
    chk("R7 gate only in last window cycle", coinc_valid, 1);
    clear_chan();
  endtask

  task automatic t_zero_view();
    view_sel = 5'd0; gate_in = 1'b1; thr_in = 1'b1;
    tick();
    chk("R4 zero setting busy", busy, 1);
    chk("R4 zero setting no window", view_win, 0);
    chk("R7 zero setting samples gate at arming", coinc_valid, 1);
    clear_chan();
  endtask

  task automatic t_disabled();
    chan_en = 1'b0; view_sel = 5'd1;
    tick();
    thr_in = 1'b1; peak_stb = 1'b1;
    tick(4);
    chk("R1 disabled busy and hold", {busy, hold_en}, 0);
    chk("R1 disabled no window or convert", {view_win, conv_pulse}, 0);
    peak_stb = 1'b0; thr_in = 1'b0; chan_en = 1'b1;
    tick();
    thr_in = 1'b1; tick();
    chk("R2 armed after enable", busy, 1);
    chan_en = 1'b0; tick();
    chk("R1 disable drops busy", {busy, hold_en}, 0);
    chan_en = 1'b1; tick(3);
    chk("R3 held level does not re-arm after enable", busy, 0);
    thr_in = 1'b0; tick();
  endtask

  task automatic t_retrig();
    int n;
    view_sel = 5'd1;
    peak_stb = 1'b1; tick(); peak_stb = 1'b0; tick();
    chk("R5 strobe while idle ignored", conv_pulse, 0);
    thr_in = 1'b1; tick();
    n = 1;
    thr_in = 1'b0; tick(10); n += 10;
    thr_in = 1'b1; tick();
    while (view_win && n < 5000) begin n++; tick(); end
    chk("R3 retrigger does not restart window", n, 50);
    fe_clr = 1'b1; tick(); fe_clr = 1'b0;
    tick(5);
    chk("R3 no re-arm on held level after clear", busy, 0);
    thr_in = 1'b0; tick();
    fe_clr = 1'b1; thr_in = 1'b1; tick();
    chk("R8 clear beats simultaneous edge", busy, 0);
    fe_clr = 1'b0; tick(3);
    chk("R3 still not armed", busy, 0);
    thr_in = 1'b0; tick();
    thr_in = 1'b1; tick();
    chk("R3 fresh edge re-arms", busy, 1);
    clear_chan();
  endtask

  task automatic t_max_view();
    int n;
    view_sel = 5'd31; gate_in = 1'b1; thr_in = 1'b1;
    tick();
    n = 0;
    while (view_win && n < 5000) begin n++; tick(); end
    chk("R4 window length sel=31", n, 1550);
    chk("R7 coinc at max view", coinc_valid, 1);
    clear_chan();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_event();
    t_gate_miss();
    t_gate_last();
    t_zero_view();
    t_disabled();
    t_retrig();
    t_max_view();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule